// File: doc/BRIEF.md
# Page-Bounded LZ77 Match Encoder

This block turns a byte stream into LZ77 tokens. It works on independent pages of 2^PAGE_W bytes, which is 4096 by default. A page begins with the first byte that arrives with `in_sop` set while the encoder is idle. Bytes are written into a page buffer as they arrive. The match search runs on the same buffer while the rest of the page is still loading, so filling the buffer and encoding overlap.

Candidate earlier positions come from a hash table. It is indexed by a hash of the next four bytes and has two entries per bucket. Each entry carries the page number it was written in, so a new page makes every older entry invalid at once, with no clearing pass. The encoder accepts the first candidate whose verified length reaches the minimum. It then checks the next position once. If the match there is strictly longer, it emits one literal and takes the later match instead.

Tokens leave on a valid/ready port. Each token is either a literal byte or an (offset, length) pair, and the last token of a page is flagged. A downstream entropy coder consumes them.

Top module: `lz_page_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While idle, a byte accepted with `in_sop`=1 becomes byte 0 of a new page. A byte accepted with `in_sop`=0 while idle is discarded. `in_sop` on a byte inside a page has no effect.
- R3: Token encoding:
  - `out_is_match`=0 means a literal; its byte is `out_lit`.
  - `out_is_match`=1 means a copy of `out_len` bytes starting `out_off` bytes back.
  - Expanding all tokens of a page in order reproduces the page exactly.
  - `out_last`=1 on the final token of each page and on no other token.
- R4: Every match has a length from 4 to MAX_LEN (255), and an offset from 1 up to its own start position in the page. It never extends past the end of the page.
- R5: No match starts in the last three positions of a page.
- R6: A match only refers back within the current page. A page that repeats the previous page byte for byte, and has no 4-byte repeat inside its first 16 bytes, emits its first 16 positions as literals.
- R7: Candidates are tried newest first, and the first one that verifies to at least 4 bytes is taken, even when an older candidate is longer. Each bucket holds two entries, and an insert pushes out the oldest. Example: with "WXYZQ" at 0, "WXYZ" at 10 and "WXYZQ" at 20, the token starting at 20 is a match with offset 10 and length 4.
- R8: Before committing a match at p, the match at p+1 is evaluated. If it is strictly longer, a literal for p is emitted, followed by the match at p+1. Example: with "BCDEFGHI" at 0, "ABCD" at 8 and "ABCDEFGHI" at 20, the tokens are a literal 0x41 at 20, then a match at 21 with offset 21 and length 8.
- R9: A page of 256 equal bytes with MAX_LEN 255 gives exactly two tokens: a literal, then a match with offset 1 and length 255.
- R10: While `out_valid`=1 and `out_ready`=0, the token stays unchanged. No token is lost or repeated.
- R11: Encoding starts before the page is fully loaded. Once the whole page has been received, `in_ready` stays 0 until the last token is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be accepted |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the first byte of a page |
| out_valid | output | 1 | Token valid |
| out_ready | input | 1 | Consumer takes the token |
| out_is_match | output | 1 | 1 for a match token, 0 for a literal |
| out_lit | output | 8 | Literal byte |
| out_off | output | PAGE_W | Backward distance of a match |
| out_len | output | LEN_W | Length of a match |
| out_last | output | 1 | Final token of the page |

## Verification
The embedded properties assume that the consumer obeys the handshake and that the producer holds a byte steady only for as long as it chooses. They make no assumption about how many pages arrive or when they arrive. The stimulus drives the ports only at the falling edge. It changes `out_ready` freely, and it starts each new page only after the previous page's last token has been taken. Discarded idle bytes are sent only at that point, so any leak of them into a page would show up as a reconstruction mismatch.

// File: rtl/lz_page_encoder.sv
module lz_page_encoder #(
  parameter int PAGE_W  = 12,
  parameter int HASH_W  = 10,
  parameter int EPOCH_W = 8,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 255,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_match,
  output logic [7:0]        out_lit,
  output logic [PAGE_W-1:0] out_off,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_last
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int CW   = PAGE_W + 1;
  localparam int NB   = 1 << HASH_W;
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_CMP, S_DEC, S_OUT} st_t;
  st_t st;

  logic [7:0]         mem [PAGE];
  logic [PAGE_W-1:0]  tpos [2][NB];
  logic [EPOCH_W-1:0] tep  [2][NB];
  logic [EPOCH_W-1:0] epoch;
  logic [CW-1:0]      wr_cnt, p, nxt_p, out_start;
  logic               lazy, ci, v0, v1, pend;
  logic [PAGE_W-1:0]  c0, c1, r_off, s_off, pend_off;
  logic [LEN_W-1:0]   k, r_len, s_len, pend_len;

  wire acc       = in_valid && in_ready;
  wire acc_start = acc && st == S_IDLE && in_sop;
  wire acc_body  = acc && st != S_IDLE;
  assign in_ready = st == S_IDLE || wr_cnt < PAGE_C;

  wire [CW-1:0]     q       = p + CW'(lazy);
  wire [PAGE_W-1:0] qa      = q[PAGE_W-1:0];
  wire              has_key = q + CW'(4) <= PAGE_C;
  wire              key_rdy = q + CW'(4) <= wr_cnt;
  wire [31:0] hk = {mem[qa], mem[qa + PAGE_W'(1)], mem[qa + PAGE_W'(2)],
                    mem[qa + PAGE_W'(3)]} * 32'h9E3779B1;
  wire [HASH_W-1:0] hidx = hk[31 -: HASH_W];
  wire hit0 = tep[0][hidx] == epoch && CW'(tpos[0][hidx]) < q;
  wire hit1 = tep[1][hidx] == epoch && CW'(tpos[1][hidx]) < q;
  wire ins  = st == S_LOOK && has_key && key_rdy;

  wire [PAGE_W-1:0] cc    = ci ? c1 : c0;
  wire              cv    = ci ? v1 : v0;
  wire [CW-1:0]     qk    = q + CW'(k);
  wire [PAGE_W-1:0] ck    = cc + PAGE_W'(k);
  wire              avail = qk < wr_cnt;
  wire              stop  = !cv || k == LEN_W'(MAX_LEN) || qk == PAGE_C;
  wire              same  = mem[ck] == mem[qk[PAGE_W-1:0]];
  wire              found = cv && k >= LEN_W'(MIN_LEN);

  always_ff @(posedge clk) begin
    if (acc_start)     mem[0] <= in_data;
    else if (acc_body) mem[wr_cnt[PAGE_W-1:0]] <= in_data;
    if (ins) begin
      tpos[1][hidx] <= tpos[0][hidx];
      tep[1][hidx]  <= tep[0][hidx];
      tpos[0][hidx] <= qa;
      tep[0][hidx]  <= epoch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         wr_cnt <= '0;
    else if (acc_start) wr_cnt <= CW'(1);
    else if (acc_body)  wr_cnt <= wr_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; epoch <= '0; p <= '0; nxt_p <= '0; lazy <= 1'b0;
      ci <= 1'b0; v0 <= 1'b0; v1 <= 1'b0; c0 <= '0; c1 <= '0; k <= '0;
      r_len <= '0; r_off <= '0; s_len <= '0; s_off <= '0;
      pend <= 1'b0; pend_off <= '0; pend_len <= '0; out_start <= '0;
      out_valid <= 1'b0; out_is_match <= 1'b0; out_lit <= '0;
      out_off <= '0; out_len <= '0; out_last <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (acc_start) begin
          epoch <= epoch + EPOCH_W'(1);
          p <= '0; lazy <= 1'b0; st <= S_LOOK;
        end
        S_LOOK: begin
          if (!has_key) begin
            if (p < wr_cnt) begin r_len <= '0; st <= S_DEC; end
          end else if (key_rdy) begin
            c0 <= tpos[0][hidx]; v0 <= hit0;
            c1 <= tpos[1][hidx]; v1 <= hit1;
            ci <= 1'b0; k <= '0; st <= S_CMP;
          end
        end
        S_CMP: begin
          if (stop || (avail && !same)) begin
            if (found) begin
              r_len <= k; r_off <= qa - cc; st <= S_DEC;
            end else if (!ci) begin
              ci <= 1'b1; k <= '0;
            end else begin
              r_len <= '0; st <= S_DEC;
            end
          end else if (avail) k <= k + LEN_W'(1);
        end
        S_DEC: begin
          out_valid <= 1'b1; out_start <= p; st <= S_OUT;
          if (!lazy && r_len >= LEN_W'(MIN_LEN)) begin
            s_len <= r_len; s_off <= r_off; lazy <= 1'b1;
            out_valid <= 1'b0; st <= S_LOOK;
          end else if (!lazy || r_len > s_len) begin
            out_is_match <= 1'b0; out_lit <= mem[p[PAGE_W-1:0]];
            out_last <= p + CW'(1) == PAGE_C;
            pend <= lazy; pend_off <= r_off; pend_len <= r_len;
            nxt_p <= lazy ? p + CW'(1) + CW'(r_len) : p + CW'(1);
          end else begin
            out_is_match <= 1'b1; out_off <= s_off; out_len <= s_len;
            out_last <= p + CW'(s_len) == PAGE_C;
            nxt_p <= p + CW'(s_len);
          end
        end
        S_OUT: if (out_ready) begin
          if (pend) begin
            pend <= 1'b0; out_is_match <= 1'b1; out_off <= pend_off;
            out_len <= pend_len; out_last <= nxt_p == PAGE_C;
            out_start <= p + CW'(1);
          end else begin
            out_valid <= 1'b0; p <= nxt_p; lazy <= 1'b0;
            st <= nxt_p == PAGE_C ? S_IDLE : S_LOOK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_is_match, out_lit, out_off, out_len, out_last}));

  // R4
  match_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_match |-> out_len >= LEN_W'(MIN_LEN) && out_len <= LEN_W'(MAX_LEN)
      && out_off != '0 && CW'(out_off) <= out_start && out_start + CW'(out_len) <= PAGE_C);

  // R5
  tail_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_match |-> out_start + CW'(3) < PAGE_C);

  // R3
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_start + (out_is_match ? CW'(out_len) : CW'(1)) == PAGE_C);
endmodule

// File: tb/lz_page_encoder_tb.sv
module lz_page_encoder_tb;
  localparam int PG = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_is_match, out_last;
  logic [7:0] out_lit, out_off, out_len;

  always #10 clk = ~clk;

  lz_page_encoder #(.PAGE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_match(out_is_match), .out_lit(out_lit), .out_off(out_off),
    .out_len(out_len), .out_last(out_last));

  int n_chk = 0, n_fail = 0, ntok = 0;
  bit done, rmode, noise, sop_mid;
  logic [7:0] pg [PG];
  logic [7:0] rec [PG];
  int t_start [600], t_m [600], t_off [600], t_len [600], t_lit [600];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive();
    int i = 0;
    if (noise) begin
      int n = 0;
      while (n < 3) begin
        @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hEE;
        #1 if (in_ready) n++;
      end
    end
    while (i < PG) begin
      @(negedge clk);
      in_valid = rmode ? 1'b1 : ($urandom % 4 != 0);
      in_data = pg[i];
      in_sop = (i == 0) || (sop_mid && i == 77);
      #1 if (in_valid && in_ready) i++;
    end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
    #1;
    chk(ntok > 0, "R11", "no token before page fully loaded", ntok, 1);
    if (!done) chk(!in_ready, "R11", "in_ready while page full", int'(in_ready), 0);
  endtask

  task automatic consume();
    int pos = 0;
    bit held = 0;
    logic [7:0] h_lit, h_off, h_len;
    logic h_m, h_last;
    ntok = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      if (held)
        chk(out_valid && out_is_match == h_m && out_lit == h_lit && out_off == h_off
            && out_len == h_len && out_last == h_last, "R10", "stalled token changed", int'(out_len), int'(h_len));
      out_ready = rmode ? 1'b1 : ($urandom % 3 != 0);
      #1;
      held = out_valid && !out_ready;
      h_m = out_is_match; h_lit = out_lit; h_off = out_off; h_len = out_len; h_last = out_last;
      if (out_valid && out_ready) begin
        if (ntok < 600) begin
          t_start[ntok] = pos; t_m[ntok] = int'(out_is_match);
          t_off[ntok] = int'(out_off); t_len[ntok] = int'(out_len); t_lit[ntok] = int'(out_lit);
        end
        ntok++;
        if (out_is_match) begin
          bit ok;
          ok = out_off >= 1 && int'(out_off) <= pos && out_len >= 4 && pos + int'(out_len) <= PG;
          chk(ok, "R4", "match offset/length", int'(out_off), pos);
          chk(pos <= PG - 4, "R5", "match starts in tail", pos, PG - 4);
          if (ok) for (int j = 0; j < int'(out_len); j++) rec[pos + j] = rec[pos - int'(out_off) + j];
          pos += int'(out_len);
        end else begin
          if (pos < PG) rec[pos] = out_lit;
          pos++;
        end
        chk(out_last == (pos == PG), "R3", "end flag placement", int'(out_last), int'(pos == PG));
        if (out_last || pos >= PG) done = 1;
      end
    end
    @(negedge clk); out_ready = 1'b0;
    chk(pos == PG, "R3", "bytes covered by tokens", pos, PG);
  endtask

  task automatic run_page();
    int bad = -1;
    fork drive(); consume(); join
    for (int i = PG - 1; i >= 0; i--) if (rec[i] !== pg[i]) bad = i;
    chk(bad < 0, "R3", "reconstructed byte index", bad, -1);
  endtask

  function automatic int find_tok(input int s);
    for (int t = 0; t < ntok && t < 600; t++) if (t_start[t] == s) return t;
    return 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R9: run of equal bytes
    rmode = 1; noise = 0; sop_mid = 0;
    for (int i = 0; i < PG; i++) pg[i] = 8'h55;
    run_page();
    chk(ntok == 2, "R9", "token count", ntok, 2);
    chk(t_m[0] == 0 && t_lit[0] == 'h55, "R9", "first token literal", t_m[0], 0);
    chk(t_m[1] == 1 && t_off[1] == 1 && t_len[1] == 255, "R9", "second token length", t_len[1], 255);

    // R3 R4 R5: periodic pages
    for (int per = 1; per <= 8; per++) begin
      rmode = per[0];
      for (int i = 0; i < PG; i++) pg[i] = 8'(per * 16 + i % per);
      run_page();
    end

    // R6: page repeated exactly in the next page
    rmode = 0;
    for (int i = 0; i < PG; i++) pg[i] = (i < 16) ? 8'(16 + i) : 8'($urandom);
    run_page();
    run_page();
    for (int i = 0; i < 16; i++)
      chk(t_start[i] == i && t_m[i] == 0, "R6", "literal expected at page start", t_m[i], 0);

    // R8: lazy look-ahead
    for (int i = 0; i < PG; i++) pg[i] = 8'(8'h80 + (i & 127));
    for (int i = 0; i < 8; i++) pg[i] = 8'(8'h42 + i);
    for (int i = 0; i < 4; i++) pg[8 + i] = 8'(8'h41 + i);
    for (int i = 0; i < 9; i++) pg[20 + i] = 8'(8'h41 + i);
    run_page();
    t = find_tok(20);
    chk(t_start[t] == 20 && t_m[t] == 0 && t_lit[t] == 'h41, "R8", "literal at 20", t_lit[t], 'h41);
    chk(t_start[t + 1] == 21 && t_m[t + 1] == 1 && t_off[t + 1] == 21 && t_len[t + 1] == 8,
        "R8", "match at 21 length", t_len[t + 1], 8);

    // R7: first-fit on newest candidate
    rmode = 1;
    for (int i = 0; i < PG; i++) pg[i] = 8'(8'h80 + (i & 127));
    for (int i = 0; i < 5; i++) begin pg[i] = 8'(8'h57 + i); pg[20 + i] = 8'(8'h57 + i); end
    pg[4] = 8'h51; pg[24] = 8'h51;
    for (int i = 0; i < 4; i++) pg[10 + i] = 8'(8'h57 + i);
    run_page();
    t = find_tok(20);
    chk(t_start[t] == 20 && t_m[t] == 1 && t_off[t] == 10 && t_len[t] == 4,
        "R7", "offset of match at 20", t_off[t], 10);

    // R2 R10 R11: small alphabet, idle noise, stray start marker
    for (int r = 0; r < 5; r++) begin
      rmode = 0; noise = (r >= 2); sop_mid = (r >= 3);
      for (int i = 0; i < PG; i++) pg[i] = 8'($urandom % (r + 2));
      run_page();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule